// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Register File

This block is the digital front of a two-channel 8-bit digital-to-analog converter. A host writes a byte over a parallel bus made of a data bus, an active-low chip select, an active-low write strobe and a channel-select line. The byte lands in a staging register for the chosen channel. A separate active-low load strobe then moves both staging registers into the output (converter) registers in the same clock. The analog stage reads the two output codes and a power-down flag.

Every input is oversampled in one clock domain through a synchronizer chain. The write is recognised on the rising edge of the synchronized write strobe. If the load strobe is held low, the output registers follow the staging registers, so each write shows up without a separate load. An active-low clear forces both output registers to zero without waiting for the clock. It keeps them at zero until it is released and resynchronized, and it leaves the staging registers alone. An active-low power-down input raises a flag for the analog stage and changes no stored code.

Top module: `dac_dual_regs`

## Requirements
- R1: A write completes when the synchronized write strobe rises while chip select is low. The byte on the bus is then stored in the staging register selected by the channel-select line (0 = channel A, 1 = channel B). Bus bit i becomes code bit i, with bit 7 the most significant.
- R2: While the load strobe is high and clear is inactive, neither output code changes, whatever writes take place.
- R3: A low pulse on the load strobe copies both staging registers into both output registers in the same clock cycle.
- R4: While the load strobe is held low, each output register follows its staging register one clock later, so a write appears on the output without a separate load.
- R5: Driving clear low sets both output codes to zero at once, without a clock edge. They stay zero until clear has been high for the synchronizer depth.
- R6: Clear does not change the staging registers, so a load after clear restores the values written before it.
- R7: Clear has priority over load. With both asserted the outputs stay zero.
- R8: A low power-down input sets the power-down flag after synchronization and leaves both output codes unchanged. Releasing it clears the flag.
- R9: A write strobe edge seen while chip select is high changes no staging register.
- R10: The synchronous active-high reset sets both staging registers, both output codes and the power-down flag to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample all inputs |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 8 | Parallel data byte, bit 7 is the MSB |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr_n | input | 1 | Write strobe, active low; data is taken on its rising edge |
| bus_sel | input | 1 | Channel select: 0 = A, 1 = B |
| load_n | input | 1 | Load strobe, active low; level-sensitive transfer of both channels |
| clear_n | input | 1 | Clear, active low; asynchronously zeroes the output registers |
| pwrdn_n | input | 1 | Power-down request, active low |
| code_a | output | 8 | Output register code of channel A |
| code_b | output | 8 | Output register code of channel B |
| pwrdn_flag | output | 1 | High while power-down is requested |

## Verification
A table of writes is run first. It mixes both channel selects, writes with chip select high and writes with and without a following load pulse. This separates storing a byte into the staging register from making it visible, and shows that deselected writes are dropped. The data values 0x80 and 0x01 show that the byte is not bit-reversed. Directed cases then sample the outputs one nanosecond after clear falls, to show that clearing needs no clock edge. They hold load and clear low together, and then reload after clear to show that the staging contents survive. They also run with load tied low, toggle power-down while the codes are nonzero, and apply reset mid-run.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/dacreg_sync.sv
module dacreg_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dacreg_clr_sync.sv
module dacreg_clr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clear_n,
  output logic clr_n_out
);
  logic [STAGES-1:0] hold;

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) hold <= '0;
    else          hold <= {hold[STAGES-2:0], 1'b1};
  end

  assign clr_n_out = hold[STAGES-1];
endmodule

// File: rtl/dacreg_in_bank.sv
module dacreg_in_bank #(
  parameter int DW  = 8,
  parameter int NCH = 2,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [SW-1:0]           sel,
  input  logic [DW-1:0]           data,
  output logic [NCH-1:0][DW-1:0]  stage_q
);
  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst)                               stage_q[c] <= '0;
        else if (wr_en && (sel == SW'(c)))     stage_q[c] <= data;
      end
    end
  endgenerate
endmodule

// File: rtl/dacreg_out_bank.sv
module dacreg_out_bank #(
  parameter int DW  = 8,
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr_n,
  input  logic                    load_on,
  input  logic [NCH-1:0][DW-1:0]  stage_q,
  output logic [NCH-1:0][DW-1:0]  out_q
);
  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)       out_q[c] <= '0;
        else if (rst)     out_q[c] <= '0;
        else if (load_on) out_q[c] <= stage_q[c];
      end
    end
  endgenerate
endmodule

// File: rtl/dac_dual_regs.sv
module dac_dual_regs #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_cs_n,
  input  logic          bus_wr_n,
  input  logic          bus_sel,
  input  logic          load_n,
  input  logic          clear_n,
  input  logic          pwrdn_n,
  output logic [DW-1:0] code_a,
  output logic [DW-1:0] code_b,
  output logic          pwrdn_flag
);
  import dacreg_pkg::*;

  localparam int NCH = NUM_CH;
  localparam int SYW = DW + 5;
  localparam logic [SYW-1:0] SY_RST = {4'b1111, 1'b0, {DW{1'b0}}};

  logic [SYW-1:0] sy_in, sy_out;
  logic [DW-1:0]  data_s, data_q;
  logic           wr_s_n, cs_s_n, load_s_n, pd_s_n, sel_s;
  logic           wr_q_n, cs_q_n, sel_q;
  logic           wr_en, load_on, clr_n_int;
  logic [NCH-1:0][DW-1:0] stage_q, out_q;

  assign sy_in = {bus_wr_n, bus_cs_n, load_n, pwrdn_n, bus_sel, bus_data};

  dacreg_sync #(.W(SYW), .STAGES(SYNC_STAGES), .RST_VAL(SY_RST)) u_sync (
    .clk(clk), .rst(rst), .d(sy_in), .q(sy_out)
  );

  assign {wr_s_n, cs_s_n, load_s_n, pd_s_n, sel_s, data_s} = sy_out;

  dacreg_clr_sync #(.STAGES(SYNC_STAGES)) u_clr (
    .clk(clk), .clear_n(clear_n), .clr_n_out(clr_n_int)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q_n <= 1'b1;
      cs_q_n <= 1'b1;
      sel_q  <= 1'b0;
      data_q <= '0;
    end else begin
      wr_q_n <= wr_s_n;
      cs_q_n <= cs_s_n;
      sel_q  <= sel_s;
      data_q <= data_s;
    end
  end

  assign wr_en   = wr_s_n && !wr_q_n && !cs_q_n;
  assign load_on = !load_s_n;

  dacreg_in_bank #(.DW(DW), .NCH(NCH)) u_in (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel_q),
    .data(data_q), .stage_q(stage_q)
  );

  dacreg_out_bank #(.DW(DW), .NCH(NCH)) u_out (
    .clk(clk), .rst(rst), .clr_n(clr_n_int), .load_on(load_on),
    .stage_q(stage_q), .out_q(out_q)
  );

  always_ff @(posedge clk) begin
    if (rst) pwrdn_flag <= 1'b0;
    else     pwrdn_flag <= !pd_s_n;
  end

  assign code_a = out_q[CH_A];
  assign code_b = out_q[CH_B];
endmodule

// File: rtl/dac_dual_regs_chk.sv
module dac_dual_regs_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          clr_n_int,
  input logic          load_on,
  input logic          cs_q_n,
  input logic          pd_s_n,
  input logic [DW-1:0] stage_a,
  input logic [DW-1:0] stage_b,
  input logic [DW-1:0] code_a,
  input logic [DW-1:0] code_b,
  input logic          pwrdn_flag
);
  // R5, R7: outputs are zero whenever the stretched clear is active
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !clr_n_int |-> (code_a == '0 && code_b == '0));

  // R2: no load, no clear -> codes hold
  p_hold_no_load_r2: assert property (@(posedge clk) disable iff (rst)
    (clr_n_int && $past(clr_n_int) && !$past(load_on))
      |-> ($stable(code_a) && $stable(code_b)));

  // R3, R4: with load active both channels take the staging values together
  p_load_both_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_n_int && $past(clr_n_int) && $past(load_on))
      |-> (code_a == $past(stage_a) && code_b == $past(stage_b)));

  // R9: deselected strobes leave the staging registers untouched
  p_ignore_cs_r9: assert property (@(posedge clk) disable iff (rst)
    cs_q_n |=> ($stable(stage_a) && $stable(stage_b)));

  // R8: the flag only rises after a synchronized power-down request
  p_pd_flag_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(pwrdn_flag) |-> !$past(pd_s_n));
endmodule

bind dac_dual_regs dac_dual_regs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .clr_n_int(clr_n_int), .load_on(load_on),
  .cs_q_n(cs_q_n), .pd_s_n(pd_s_n),
  .stage_a(stage_q[0]), .stage_b(stage_q[1]),
  .code_a(code_a), .code_b(code_b), .pwrdn_flag(pwrdn_flag)
);

// File: tb/tb_dac_dual_regs.sv
module tb_dac_dual_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_data = '0;
  logic       bus_cs_n = 1'b1, bus_wr_n = 1'b1, bus_sel = 1'b0;
  logic       load_n = 1'b1, clear_n = 1'b1, pwrdn_n = 1'b1;
  logic [7:0] code_a, code_b;
  logic       pwrdn_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  dac_dual_regs dut (
    .clk(clk), .rst(rst), .bus_data(bus_data), .bus_cs_n(bus_cs_n),
    .bus_wr_n(bus_wr_n), .bus_sel(bus_sel), .load_n(load_n),
    .clear_n(clear_n), .pwrdn_n(pwrdn_n),
    .code_a(code_a), .code_b(code_b), .pwrdn_flag(pwrdn_flag)
  );

  // vector fields: [26] cs_n, [25] sel, [24:17] data, [16] load after,
  // [15:8] expected code_a, [7:0] expected code_b
  localparam int NV = 6;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h3C, 1'b0, 8'h00, 8'h00},
    {1'b0, 1'b1, 8'hA5, 1'b1, 8'h3C, 8'hA5},
    {1'b1, 1'b0, 8'hFF, 1'b1, 8'h3C, 8'hA5},
    {1'b0, 1'b0, 8'h80, 1'b0, 8'h3C, 8'hA5},
    {1'b0, 1'b1, 8'h01, 1'b1, 8'h80, 8'h01},
    {1'b1, 1'b1, 8'h77, 1'b1, 8'h80, 8'h01}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic cs_n, input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_cs_n = cs_n; bus_sel = sel; bus_data = d; bus_wr_n = 1'b0;
    cyc(3);
    bus_wr_n = 1'b1;
    cyc(2);
    bus_cs_n = 1'b1;
    cyc(6);
  endtask

  task automatic load_pulse;
    @(negedge clk);
    load_n = 1'b0;
    cyc(3);
    load_n = 1'b1;
    cyc(6);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(1);
    // R10: reset state
    chk("R10 code_a after reset", code_a, 8'h00);
    chk("R10 code_b after reset", code_b, 8'h00);
    chk("R10 flag after reset", {7'b0, pwrdn_flag}, 8'h00);

    // R1 R2 R3 R9: table walk
    for (int v = 0; v < NV; v++) begin
      bus_write(VEC[v][26], VEC[v][25], VEC[v][24:17]);
      if (VEC[v][16]) load_pulse();
      chk($sformatf("R1/R2/R3/R9 vec%0d code_a", v), code_a, VEC[v][15:8]);
      chk($sformatf("R1/R2/R3/R9 vec%0d code_b", v), code_b, VEC[v][7:0]);
    end

    // R8: power-down raises flag, codes held
    @(negedge clk); pwrdn_n = 1'b0;
    cyc(5);
    chk("R8 flag set", {7'b0, pwrdn_flag}, 8'h01);
    chk("R8 code_a held", code_a, 8'h80);
    chk("R8 code_b held", code_b, 8'h01);
    pwrdn_n = 1'b1;
    cyc(5);
    chk("R8 flag released", {7'b0, pwrdn_flag}, 8'h00);

    // R5: asynchronous clear, observed before any clock edge
    @(negedge clk);
    #2 clear_n = 1'b0;
    #1;
    chk("R5 code_a async clear", code_a, 8'h00);
    chk("R5 code_b async clear", code_b, 8'h00);

    // R7: load asserted during clear keeps outputs at zero
    @(negedge clk); load_n = 1'b0;
    cyc(5);
    chk("R7 code_a clear over load", code_a, 8'h00);
    chk("R7 code_b clear over load", code_b, 8'h00);
    load_n = 1'b1;
    clear_n = 1'b1;
    cyc(6);
    chk("R5 code_a stays zero after release", code_a, 8'h00);

    // R6: staging survived clear
    load_pulse();
    chk("R6 code_a restored", code_a, 8'h80);
    chk("R6 code_b restored", code_b, 8'h01);

    // R4: load tied low -> writes pass straight through
    @(negedge clk); load_n = 1'b0;
    bus_write(1'b0, 1'b0, 8'h5A);
    chk("R4 code_a transparent", code_a, 8'h5A);
    chk("R4 code_b unchanged", code_b, 8'h01);
    bus_write(1'b0, 1'b1, 8'hC3);
    chk("R4 code_b transparent", code_b, 8'hC3);
    bus_write(1'b1, 1'b1, 8'h11);
    chk("R9 code_b deselected in tied mode", code_b, 8'hC3);
    load_n = 1'b1;

    // R10: reset mid-run clears staging too
    @(negedge clk); rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(1);
    chk("R10 code_a mid reset", code_a, 8'h00);
    load_pulse();
    chk("R10 staging b cleared", code_b, 8'h00);

    done = 1'b1;
    finish_run();
  end
endmodule